// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). It runs one Clause 22 read or write frame at a time. Software programs it through two 16-bit registers: a command word and a data word. The command word holds the target PHY address, the register index, a 4-bit clock-range code, a direction flag and a self-clearing busy flag. The data word holds the value to be written, or the value returned by the PHY.

For a write, software first stores the 16-bit value in the data word. It then writes the command word with busy set. For a read, software writes the command word with busy set and the direction flag clear. It polls busy and then fetches the result from the data word. The block derives MDC from the system clock through a divider picked by the clock-range code. It shifts the 64-bit frame out MSB first and releases MDIO for the turnaround and data bits of a read.

The frame engine is a state machine with five states:
- IDLE: no frame is running.
- PREAMBLE: the 32 preamble ones.
- HEADER: start, opcode, PHY address and register index.
- TURN: the two turnaround bits.
- DATA: the sixteen data bits.

Each move to the next state happens on an MDC falling edge. The transitions are:
- IDLE→PREAMBLE when a command is launched.
- PREAMBLE→HEADER after frame bit 31.
- HEADER→TURN after bit 45.
- TURN→DATA after bit 47.
- DATA→IDLE after bit 63.

Top module: `mdio_mgmt_master`

## Requirements
- R1: With `csr_sel`=0, `csr_rdata` returns the command word. PHY address is in [15:11], register index in [10:6], clock-range code in [5:2], the write flag in [1] (1 = write, 0 = read) and the live busy flag in [0]. All bits are 0 after reset.
- R2: With `csr_sel`=1, the data word is written and read back unchanged. Its reset value is 0.
- R3: A command write with bit 0 = 1 while idle makes busy read 1 from the next cycle and starts a frame. A command write with bit 0 = 0 while idle only updates the fields, and MDC stays low.
- R4: Busy stays 1 for exactly 64 MDC periods. It clears on the same clock edge as the last MDC falling edge.
- R5: The frame goes out MSB first, in this order: 32 ones, start 01, opcode (10 = read, 01 = write), 5-bit PHY address, 5-bit register index, 2 turnaround bits, 16 data bits. `mdio_o` changes only at launch or on an MDC falling edge.
- R6: On a read, `mdio_oe` is 0 for frame bits 46 to 63. `mdio_i` is sampled on each MDC rising edge of the data bits. The 16 sampled bits, first one as MSB, appear in the data word when busy clears.
- R7: On a write, `mdio_oe` is 1 for all 64 bits. The turnaround is 1 then 0, and the data bits are the data word as it stood at launch.
- R8: One MDC period equals a whole number of system clocks, picked from the code. Codes 0 to 7 give 4, 6, 8, 12, 16, 24, 32 and 64 clocks. Codes 8 to 15 fall back to 128. Each period starts with the low half.
- R9: A command write while busy is 1 is ignored. The fields and busy are unchanged and the running frame continues as before.
- R10: While idle, MDC is low and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 command word, 1 data word |
| csr_wdata | input | 16 | Register write value |
| csr_rdata | output | 16 | Register read value for the selected word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o (1 = master drives) |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
The engine is driven with several frame types:
- A write frame with a mixed address and data pattern. This exposes bit-order and turnaround errors.
- Reads with a PHY that returns patterns with set MSB and LSB. This separates sampling on the rising edge from sampling on the falling edge, and a shift toward the MSB from one toward the LSB.
- Clock codes from the smallest ratio, through the middle of the table, up to an undefined code. These separate the table entries from the fallback to the largest divider.

A command written in the middle of a frame checks that a busy master keeps its fields and its timing. A command with busy clear checks that updating the fields does not launch a frame. A behavioural model of MDC, MDIO and busy is compared on every clock, so any shift of one cycle in an edge shows up.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int CODE_W     = 4;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 2 + 2 + PHY_W + REG_W;
    localparam int TA_BITS    = 2;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int HALF_W     = 8;

    localparam int LAST_PRE = PRE_BITS - 1;
    localparam int LAST_HDR = PRE_BITS + HDR_BITS - 1;
    localparam int LAST_TA  = PRE_BITS + HDR_BITS + TA_BITS - 1;
    localparam int LAST_BIT = FRAME_BITS - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    // Half of the MDC period, in system clocks, for each clock-range code.
    function automatic logic [HALF_W-1:0] half_period(input logic [CODE_W-1:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            4'd0:    h = 8'd2;
            4'd1:    h = 8'd3;
            4'd2:    h = 8'd4;
            4'd3:    h = 8'd6;
            4'd4:    h = 8'd8;
            4'd5:    h = 8'd12;
            4'd6:    h = 8'd16;
            4'd7:    h = 8'd32;
            default: h = 8'd64;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio_csr_bank.sv
module mdio_csr_bank
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_value,
    output logic              start,
    output logic [PHY_W-1:0]  phy_q,
    output logic [REG_W-1:0]  reg_q,
    output logic [CODE_W-1:0] code_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int CODE_LSB = 2;
    localparam int REG_LSB  = CODE_LSB + CODE_W;
    localparam int PHY_LSB  = REG_LSB + REG_W;

    logic cmd_wr;

    assign cmd_wr = csr_we && !csr_sel && !busy;
    assign start  = cmd_wr && csr_wdata[0];

    // Command fields: locked while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q  <= '0;
            reg_q  <= '0;
            code_q <= '0;
            wr_q   <= 1'b0;
        end else if (cmd_wr) begin
            phy_q  <= csr_wdata[PHY_LSB +: PHY_W];
            reg_q  <= csr_wdata[REG_LSB +: REG_W];
            code_q <= csr_wdata[CODE_LSB +: CODE_W];
            wr_q   <= csr_wdata[1];
        end
    end

    // Data word: a finishing read takes priority over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_value;
        end else if (csr_we && csr_sel) begin
            data_q <= csr_wdata;
        end
    end

    always_comb begin
        if (csr_sel) begin
            csr_rdata = data_q;
        end else begin
            csr_rdata = {phy_q, reg_q, code_q, wr_q, busy};
        end
    end

endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              mdc,
    output logic              rise_evt,
    output logic              fall_evt
);

    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] cnt_q;
    logic              tick;

    assign half     = half_period(code);
    assign tick     = run && (cnt_q == half - 1'b1);
    assign rise_evt = tick && !mdc;
    assign fall_evt = tick && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PHY_W-1:0]  st_phy,
    input  logic [REG_W-1:0]  st_reg,
    input  logic              st_write,
    input  logic [DATA_W-1:0] st_data,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);

    localparam logic [BIT_W-1:0] B_PRE  = BIT_W'(LAST_PRE);
    localparam logic [BIT_W-1:0] B_HDR  = BIT_W'(LAST_HDR);
    localparam logic [BIT_W-1:0] B_TA   = BIT_W'(LAST_TA);
    localparam logic [BIT_W-1:0] B_LAST = BIT_W'(LAST_BIT);

    frame_state_e            state_q, state_d;
    logic [BIT_W-1:0]        bit_q;
    logic [FRAME_BITS-1:0]   shift_q;
    logic [FRAME_BITS-1:0]   frame_w;
    logic [DATA_W-1:0]       rx_q;
    logic                    write_q;
    logic                    out_q;
    logic                    last_bit;

    assign frame_w = {{PRE_BITS{1'b1}}, 2'b01,
                      (st_write ? 2'b01 : 2'b10),
                      st_phy, st_reg,
                      (st_write ? 2'b10 : 2'b11),
                      (st_write ? st_data : {DATA_W{1'b0}})};

    assign last_bit = fall_evt && (bit_q == B_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)                       state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_evt && bit_q == B_PRE)  state_d = ST_HEADER;
            ST_HEADER:   if (fall_evt && bit_q == B_HDR)  state_d = ST_TURN;
            ST_TURN:     if (fall_evt && bit_q == B_TA)   state_d = ST_DATA;
            ST_DATA:     if (last_bit)                    state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shifter, bit counter and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_q   <= '0;
            write_q <= 1'b0;
            out_q   <= 1'b1;
            rx_q    <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                shift_q <= frame_w;
                bit_q   <= '0;
                write_q <= st_write;
                out_q   <= frame_w[FRAME_BITS-1];
            end
        end else begin
            if (rise_evt && state_q == ST_DATA && !write_q) begin
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            end
            if (fall_evt) begin
                if (bit_q == B_LAST) begin
                    out_q <= 1'b1;
                end else begin
                    shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
                    out_q   <= shift_q[FRAME_BITS-2];
                    bit_q   <= bit_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:              mdio_oe = 1'b0;
            ST_PREAMBLE,
            ST_HEADER:            mdio_oe = 1'b1;
            ST_TURN, ST_DATA:     mdio_oe = write_q;
            default:              mdio_oe = 1'b0;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign mdio_o   = out_q;
    assign rd_done  = last_bit && (state_q == ST_DATA) && !write_q;
    assign rd_value = rx_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic        csr_sel,
    input  logic [15:0] csr_wdata,
    output logic [15:0] csr_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              busy_w;
    logic              start_w;
    logic              rd_done_w;
    logic [DATA_W-1:0] rd_value_w;
    logic [PHY_W-1:0]  phy_w;
    logic [REG_W-1:0]  reg_w;
    logic [CODE_W-1:0] code_w;
    logic              wr_w;
    logic [DATA_W-1:0] data_w;
    logic              rise_w;
    logic              fall_w;
    logic [DATA_W-2:0] cmd_view;

    assign cmd_view = {phy_w, reg_w, code_w, wr_w};

    mdio_csr_bank u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .busy      (busy_w),
        .rd_done   (rd_done_w),
        .rd_value  (rd_value_w),
        .start     (start_w),
        .phy_q     (phy_w),
        .reg_q     (reg_w),
        .code_q    (code_w),
        .wr_q      (wr_w),
        .data_q    (data_w)
    );

    mdio_clk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_w),
        .code     (code_w),
        .mdc      (mdc),
        .rise_evt (rise_w),
        .fall_evt (fall_w)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .st_phy   (csr_wdata[15:11]),
        .st_reg   (csr_wdata[10:6]),
        .st_write (csr_wdata[1]),
        .st_data  (data_w),
        .rise_evt (rise_w),
        .fall_evt (fall_w),
        .mdio_i   (mdio_i),
        .busy     (busy_w),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done_w),
        .rd_value (rd_value_w)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_we,
    input logic        csr_sel,
    input logic [15:0] csr_wdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [14:0] cmd_fields
);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    a_r4_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc));

    a_r5_out_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));

    a_r9_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !csr_sel && busy) |=> ($stable(cmd_fields) && busy));

    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !csr_sel && csr_wdata[0] && !busy) |=> (busy && !mdc && mdio_oe));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_we     (csr_we),
    .csr_sel    (csr_sel),
    .csr_wdata  (csr_wdata),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .busy       (busy_w),
    .cmd_fields (cmd_view)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic        csr_sel = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // MDC period in system clocks for a code (R8)
    function automatic int period_of(input logic [3:0] code);
        case (code)
            4'd0: return 4;
            4'd1: return 6;
            4'd2: return 8;
            4'd3: return 12;
            4'd4: return 16;
            4'd5: return 24;
            4'd6: return 32;
            4'd7: return 64;
            default: return 128;
        endcase
    endfunction

    function automatic logic [63:0] exp_frame(input logic [4:0] phy, input logic [4:0] rg,
                                              input bit wr, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b11), (wr ? d : 16'h0)};
    endfunction

    // Behavioural reference model, updated on every rising edge
    bit          m_busy = 0, m_mdc = 0, m_oe = 0, m_out = 1, m_wr = 0, m_pb = 0, m_done = 0;
    int          m_cnt = 0, m_bit = 0, m_half = 2;
    logic [63:0] m_frame = '0;
    logic [15:0] m_data = '0, m_rx = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_mdc = 0; m_oe = 0; m_out = 1; m_cnt = 0; m_bit = 0;
            m_data = '0; m_rx = '0;
        end else begin
            m_pb = m_busy;
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == m_half - 1) begin
                    m_cnt = 0;
                    if (!m_mdc) begin
                        m_mdc = 1;
                        if (!m_wr && m_bit >= 48) m_rx = {m_rx[14:0], mdio_i};
                    end else begin
                        m_mdc = 0;
                        if (m_bit == 63) begin
                            m_busy = 0; m_oe = 0; m_out = 1;
                            if (!m_wr) m_done = 1;
                        end else begin
                            m_bit++;
                            m_out = m_frame[63 - m_bit];
                            m_oe = m_wr || (m_bit < 46);
                        end
                    end
                end else begin
                    m_cnt++;
                end
            end
            if (csr_we) begin
                if (csr_sel) m_data = csr_wdata;
                else if (!m_pb && csr_wdata[0]) begin
                    m_wr = csr_wdata[1];
                    m_half = period_of(csr_wdata[5:2]) / 2;
                    m_frame = exp_frame(csr_wdata[15:11], csr_wdata[10:6], csr_wdata[1], m_data);
                    m_busy = 1; m_cnt = 0; m_mdc = 0; m_bit = 0; m_oe = 1;
                    m_out = m_frame[63];
                end
            end
            if (m_done) m_data = m_rx;
        end
    end

    // Per-clock comparison, PHY responder, capture and busy counting
    logic [63:0] cap = '0;
    logic [15:0] phy_val = '0;
    int          rcount = 0;
    int          busy_cnt = 0;
    bit          prev_mdc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        #2;
        if (rst_n) begin
            chk(mdc == m_mdc, "R8 mdc timing", 64'(mdc), 64'(m_mdc));
            chk(mdio_oe == m_oe, "R6/R7 mdio_oe", 64'(mdio_oe), 64'(m_oe));
            if (m_oe) chk(mdio_o == m_out, "R5 mdio_o bit", 64'(mdio_o), 64'(m_out));
            if (!csr_sel) begin
                chk(csr_rdata[0] == m_busy, "R4 busy flag", 64'(csr_rdata[0]), 64'(m_busy));
                if (csr_rdata[0]) busy_cnt++;
            end
            if (mdc && !prev_mdc) begin
                if (mdio_oe && rcount < 64) cap[63 - rcount] = mdio_o;
                rcount++;
                if (rcount >= 48 && rcount < 64) mdio_i = phy_val[63 - rcount];
                else mdio_i = 1'b0;
            end
        end
        prev_mdc = mdc;
    end

    task automatic bus_wr(input bit sel, input logic [15:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_sel = 1'b0;
    endtask

    task automatic bus_rd(input bit sel, output logic [15:0] d);
        @(negedge clk);
        csr_sel = sel;
        #1 d = csr_rdata;
        csr_sel = 1'b0;
    endtask

    task automatic launch(input logic [4:0] phy, input logic [4:0] rg, input logic [3:0] code,
                          input bit wr, input logic [15:0] pv);
        phy_val = pv; rcount = 0; busy_cnt = 0; cap = '0;
        bus_wr(1'b0, {phy, rg, code, wr, 1'b1});
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (csr_rdata[0] || csr_sel) @(negedge clk);
        @(negedge clk);
    endtask

    logic [15:0] rd;
    logic [63:0] ef;

    initial begin
        repeat (3) @(negedge clk);
        // R10 / R1 / R2 reset state
        bus_rd(1'b0, rd); chk(rd == 16'h0, "R1 reset command word", 64'(rd), 0);
        bus_rd(1'b1, rd); chk(rd == 16'h0, "R2 reset data word", 64'(rd), 0);
        chk(!mdc && !mdio_oe, "R10 idle outputs in reset", 64'({mdc, mdio_oe}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mdc && !mdio_oe, "R10 idle outputs", 64'({mdc, mdio_oe}), 0);

        // R2 data word readback
        bus_wr(1'b1, 16'hA5C3);
        bus_rd(1'b1, rd); chk(rd == 16'hA5C3, "R2 data readback", 64'(rd), 64'h A5C3);

        // R3 / R1: fields only, no launch
        bus_wr(1'b0, {5'd5, 5'd3, 4'd2, 1'b1, 1'b0});
        repeat (10) @(negedge clk);
        bus_rd(1'b0, rd);
        chk(rd == {5'd5, 5'd3, 4'd2, 1'b1, 1'b0}, "R1 R3 field update without launch", 64'(rd),
            64'({5'd5, 5'd3, 4'd2, 1'b1, 1'b0}));
        chk(!mdc && !mdio_oe, "R3 no frame started", 64'({mdc, mdio_oe}), 0);

        // Write frame, code 0, with a command injected mid-frame (R9)
        bus_wr(1'b1, 16'hBEEF);
        launch(5'h11, 5'h0A, 4'd0, 1'b1, 16'h0);
        repeat (60) @(negedge clk);
        bus_wr(1'b0, {5'h02, 5'h1F, 4'd7, 1'b0, 1'b1});
        wait_done();
        ef = exp_frame(5'h11, 5'h0A, 1'b1, 16'hBEEF);
        chk(cap == ef, "R5 R7 write frame bits", cap, ef);
        chk(busy_cnt == 64 * 4, "R4 R8 write busy length code 0", 64'(busy_cnt), 64'(256));
        bus_rd(1'b0, rd);
        chk(rd == {5'h11, 5'h0A, 4'd0, 1'b1, 1'b0}, "R9 command ignored while busy", 64'(rd),
            64'({5'h11, 5'h0A, 4'd0, 1'b1, 1'b0}));

        // Read frame, code 3
        launch(5'h1F, 5'h01, 4'd3, 1'b0, 16'h3C96);
        wait_done();
        ef = exp_frame(5'h1F, 5'h01, 1'b0, 16'h0);
        chk(cap[63:18] == ef[63:18], "R5 read header bits", 64'(cap[63:18]), 64'(ef[63:18]));
        chk(cap[17:0] == 18'h0, "R6 released during turnaround and data", 64'(cap[17:0]), 0);
        bus_rd(1'b1, rd); chk(rd == 16'h3C96, "R6 read data", 64'(rd), 64'h3C96);
        chk(busy_cnt == 64 * 12, "R8 busy length code 3", 64'(busy_cnt), 64'(768));

        // Read frame, code 7, edge pattern
        launch(5'h00, 5'h10, 4'd7, 1'b0, 16'h8001);
        wait_done();
        bus_rd(1'b1, rd); chk(rd == 16'h8001, "R6 read data msb lsb", 64'(rd), 64'h8001);
        chk(busy_cnt == 64 * 64, "R8 busy length code 7", 64'(busy_cnt), 64'(4096));

        // Read frame, undefined code falls back to 128
        launch(5'h0C, 5'h1B, 4'd13, 1'b0, 16'h5AF0);
        wait_done();
        bus_rd(1'b1, rd); chk(rd == 16'h5AF0, "R6 read data slow", 64'(rd), 64'h5AF0);
        chk(busy_cnt == 64 * 128, "R8 fallback divider", 64'(busy_cnt), 64'(8192));
        chk(!mdc && !mdio_oe, "R10 idle after frames", 64'({mdc, mdio_oe}), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule